// File: doc/BRIEF.md
# Packed-Decimal Add/Subtract Unit

An 8-bit arithmetic unit for a processor datapath. Each operation is either add-with-carry or subtract-with-borrow, on two-digit packed BCD or on plain binary bytes. It returns a result byte and four flags: negative (N), overflow (V), zero (Z) and carry (C).

A run-time variant input selects one of two decimal-mode behaviours:

- The older NMOS rules take some flags from the plain binary result or from an intermediate value.
- The later CMOS rules take N and Z from the final adjusted byte and use a different subtract correction.

Every one of the 256 x 256 operand pairs gives a defined result. This includes operands with non-decimal digits (A-F), where the exact adjust sequence described below is reproduced.

The unit samples its operands and mode inputs on a clock edge where `valid_i` is high. The result and flags appear one clock later, together with `valid_o`.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `result_o` and all four flags are 0.
- R2: `valid_o` is high exactly one clock after an edge that sampled `valid_i` high. When `valid_i` is low, the result and flags keep their previous values.
- R3: Binary add (`dec_i`=0, `sub_i`=0). The result is `(a + b + carry_i) mod 256`. C is bit 8 of that sum. V is signed overflow. N is result bit 7. Z is set when the result is zero.
- R4: Binary subtract (`dec_i`=0, `sub_i`=1). The unit computes `a + ~b + carry_i`. `carry_i`=1 means no borrow in, and C=1 means no borrow out. V, N and Z are as in R3.
- R5: Decimal add, result and C, both variants:
  - Low digit: take `lo = a[3:0] + b[3:0] + carry_i`. If `lo` is at least 10, add 6, keep 4 bits, and set a digit carry.
  - High digit: form `t = (a[7:4],lo) + (b[7:4],0) + 16*digit_carry`.
  - Correction: if `t` is at least 0xA0, add 0x60 and set C=1. Otherwise C=0.
  - If both operands are valid BCD, the result is valid BCD.
- R6: Decimal add, NMOS (`cmos_i`=0). N is bit 7 of `t` before the 0x60 correction. V is set when `a[7]` equals `b[7]` and `t[7]` differs from them. Z is the Z of the binary add of the same operands.
- R7: Decimal add, CMOS (`cmos_i`=1). N is bit 7 of the final result. Z is set when the final result is zero. V is the same intermediate overflow as in R6.
- R8: Decimal subtract, NMOS:
  - Low digit: take `lo = a[3:0] - b[3:0] - !carry_i`. On a borrow, subtract 6, keep 4 bits, and borrow 16 from the high part.
  - High part: form `t = (a[7:4],lo) - (b[7:4],0) - 16*digit_borrow`.
  - If `t` is negative, subtract 0x60. The result is the low 8 bits.
  - If both operands are valid BCD, the result is valid BCD.
- R9: Decimal subtract, NMOS. N, V, Z and C equal the flags of the binary subtraction of the same operands.
- R10: Decimal subtract, CMOS. Same as R8, with two changes. On a low-digit borrow the 6 is not subtracted at the nibble stage. Instead, 6 is subtracted from the byte after the 0x60 correction.
- R11: Decimal subtract, CMOS. N and Z come from the final result. V and C come from the binary subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are sampled on this edge |
| op_a_i | input | 8 | First operand (minuend for subtract) |
| op_b_i | input | 8 | Second operand (subtrahend for subtract) |
| carry_i | input | 1 | Carry in; for subtract, 1 means no borrow |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| dec_i | input | 1 | 1 = packed BCD, 0 = binary |
| cmos_i | input | 1 | 1 = CMOS flag and adjust rules, 0 = NMOS rules |
| valid_o | output | 1 | Result is for the last sampled operation |
| result_o | output | 8 | Result byte |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag (1 = no borrow for subtract) |

## Verification
The assertions assume that operands and mode inputs are meaningful only on an edge where `valid_i` is high. The decimal-closure checks assume both operands hold valid BCD digits, and their antecedents restrict them to that case, so invalid-digit pairs are checked only by the bench's arithmetic model.

The stimulus covers the following:
- All 256 values of the first operand.
- A strided set of second operands that includes non-decimal digits.
- Both carry-in values, and every combination of mode, operation and variant.

Inputs change only at the falling clock edge. This keeps every sample clear of the active edge.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;

  function automatic logic is_bcd(input logic [BYTE_W-1:0] x);
    return (x[NIB_W-1:0] <= 4'd9) && (x[BYTE_W-1:NIB_W] <= 4'd9);
  endfunction
endpackage

// File: rtl/bcd_bin_addsub.sv
module bcd_bin_addsub
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] sum_o,
  output alu_flags_t        flags_o
);
  logic [BYTE_W-1:0] b_op;
  logic [BYTE_W:0]   s;

  always_comb begin
    b_op = sub_i ? ~b_i : b_i;
    s    = {1'b0, a_i} + {1'b0, b_op} + {{BYTE_W{1'b0}}, cin_i};
    sum_o     = s[BYTE_W-1:0];
    flags_o.n = s[BYTE_W-1];
    flags_o.v = (a_i[BYTE_W-1] == b_op[BYTE_W-1]) && (s[BYTE_W-1] != a_i[BYTE_W-1]);
    flags_o.z = (s[BYTE_W-1:0] == '0);
    flags_o.c = s[BYTE_W];
  end
endmodule

// File: rtl/bcd_dec_add.sv
module bcd_dec_add
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              carry_o,
  output logic              mid_n_o,
  output logic              mid_v_o
);
  logic [NIB_W:0]    lo_sum;
  logic              lo_cy;
  logic [NIB_W-1:0]  lo_adj;
  logic [BYTE_W:0]   hi_sum;
  logic              fix;

  always_comb begin
    lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    lo_cy  = (lo_sum >= 5'd10);
    lo_adj = lo_cy ? (lo_sum[NIB_W-1:0] + 4'd6) : lo_sum[NIB_W-1:0];
    // high digits added on top of the adjusted low digit, carry enters at bit 4
    hi_sum = {1'b0, a_i[BYTE_W-1:NIB_W], lo_adj}
           + {1'b0, b_i[BYTE_W-1:NIB_W], {NIB_W{1'b0}}}
           + {{NIB_W{1'b0}}, lo_cy, {NIB_W{1'b0}}};
    fix     = hi_sum[BYTE_W] || (hi_sum[BYTE_W-1:0] >= 8'hA0);
    res_o   = hi_sum[BYTE_W-1:0] + (fix ? 8'h60 : 8'h00);
    carry_o = fix;
    mid_n_o = hi_sum[BYTE_W-1];
    mid_v_o = (a_i[BYTE_W-1] == b_i[BYTE_W-1]) && (hi_sum[BYTE_W-1] != a_i[BYTE_W-1]);
  end
endmodule

// File: rtl/bcd_dec_sub.sv
module bcd_dec_sub
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              cmos_i,
  output logic [BYTE_W-1:0] res_o
);
  logic [NIB_W:0]    lo_dif;
  logic              lo_bw;
  logic [NIB_W-1:0]  lo_adj;
  logic [BYTE_W:0]   hi_dif;
  logic [BYTE_W-1:0] stage;

  always_comb begin
    lo_dif = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, ~cin_i};
    lo_bw  = lo_dif[NIB_W];
    // NMOS corrects the digit here; CMOS defers the 6 to the end
    lo_adj = (lo_bw && !cmos_i) ? (lo_dif[NIB_W-1:0] - 4'd6) : lo_dif[NIB_W-1:0];
    hi_dif = {1'b0, a_i[BYTE_W-1:NIB_W], lo_adj}
           - {1'b0, b_i[BYTE_W-1:NIB_W], {NIB_W{1'b0}}}
           - {{NIB_W{1'b0}}, lo_bw, {NIB_W{1'b0}}};
    stage  = hi_dif[BYTE_W-1:0] - (hi_dif[BYTE_W] ? 8'h60 : 8'h00);
    res_o  = stage - ((lo_bw && cmos_i) ? 8'h06 : 8'h00);
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] op_a_i,
  input  logic [BYTE_W-1:0] op_b_i,
  input  logic              carry_i,
  input  logic              sub_i,
  input  logic              dec_i,
  input  logic              cmos_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_v_o,
  output logic              flag_z_o,
  output logic              flag_c_o
);
  logic [BYTE_W-1:0] bin_sum, dadd_res, dsub_res, nxt_res;
  alu_flags_t        bin_flags, nxt_flags;
  logic              dadd_c, dadd_mid_n, dadd_mid_v;

  bcd_bin_addsub u_bin (
    .a_i(op_a_i), .b_i(op_b_i), .cin_i(carry_i), .sub_i(sub_i),
    .sum_o(bin_sum), .flags_o(bin_flags)
  );

  bcd_dec_add u_dadd (
    .a_i(op_a_i), .b_i(op_b_i), .cin_i(carry_i),
    .res_o(dadd_res), .carry_o(dadd_c), .mid_n_o(dadd_mid_n), .mid_v_o(dadd_mid_v)
  );

  bcd_dec_sub u_dsub (
    .a_i(op_a_i), .b_i(op_b_i), .cin_i(carry_i), .cmos_i(cmos_i),
    .res_o(dsub_res)
  );

  always_comb begin
    nxt_res   = bin_sum;
    nxt_flags = bin_flags;
    if (dec_i && !sub_i) begin
      nxt_res     = dadd_res;
      nxt_flags.c = dadd_c;
      nxt_flags.v = dadd_mid_v;
      nxt_flags.n = cmos_i ? dadd_res[BYTE_W-1] : dadd_mid_n;
      nxt_flags.z = cmos_i ? (dadd_res == '0) : bin_flags.z;
    end else if (dec_i) begin
      nxt_res = dsub_res;
      if (cmos_i) begin
        nxt_flags.n = dsub_res[BYTE_W-1];
        nxt_flags.z = (dsub_res == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      {flag_n_o, flag_v_o, flag_z_o, flag_c_o} <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= nxt_res;
        {flag_n_o, flag_v_o, flag_z_o, flag_c_o} <= nxt_flags;
      end
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable({flag_n_o, flag_v_o, flag_z_o, flag_c_o})));
  assert_bin_nz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec_i) |=> ((flag_z_o == (result_o == '0)) && (flag_n_o == result_o[BYTE_W-1])));
  assert_add_bcd_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_i && !sub_i && is_bcd(op_a_i) && is_bcd(op_b_i)) |=> is_bcd(result_o));
  assert_nmos_add_z_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_i && !sub_i && !cmos_i) |=> (flag_z_o == $past(bin_flags.z)));
  assert_cmos_add_nz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_i && !sub_i && cmos_i) |=> ((flag_z_o == (result_o == '0)) && (flag_n_o == result_o[BYTE_W-1])));
  assert_sub_bcd_closed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_i && sub_i && is_bcd(op_a_i) && is_bcd(op_b_i)) |=> is_bcd(result_o));
  assert_nmos_sub_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_i && sub_i && !cmos_i) |=> ({flag_n_o, flag_v_o, flag_z_o, flag_c_o} == $past(bin_flags)));
  assert_cmos_sub_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_i && sub_i && cmos_i) |=> ((flag_z_o == (result_o == '0)) && (flag_n_o == result_o[BYTE_W-1])
      && (flag_c_o == $past(bin_flags.c)) && (flag_v_o == $past(bin_flags.v))));
endmodule

// File: tb/sim_bcd_alu.sv
`timescale 1ns/1ps
module sim_bcd_alu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] op_a_i = '0, op_b_i = '0;
  logic       carry_i = 1'b0, sub_i = 1'b0, dec_i = 1'b0, cmos_i = 1'b0;
  logic       valid_o;
  logic [7:0] result_o;
  logic       flag_n_o, flag_v_o, flag_z_o, flag_c_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_alu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .carry_i(carry_i),
    .sub_i(sub_i), .dec_i(dec_i), .cmos_i(cmos_i),
    .valid_o(valid_o), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model returns {result[7:0], n, v, z, c}
  function automatic int model(input int a, input int b, input int c, input int sb,
                               input int dm, input int cm);
    int r, n, v, z, cy, bs, bn, bv, bz, bc, lo, hc, t, lo4, bw, sa, sbb;
    bs = sb ? (a + (255 - b) + c) : (a + b + c);
    bn = (bs % 256) >= 128;
    bz = (bs % 256) == 0;
    bc = bs >= 256;
    sa = a >= 128;
    sbb = sb ? (b < 128) : (b >= 128);
    bv = (sa == sbb) && (bn != sa);
    r = bs % 256; n = bn; v = bv; z = bz; cy = bc;
    if (dm && !sb) begin
      lo = (a % 16) + (b % 16) + c;
      hc = lo >= 10;
      if (hc) lo = (lo + 6) % 16;
      t = (a / 16) * 16 + lo + (b / 16) * 16 + hc * 16;
      v = ((a >= 128) == (b >= 128)) && (((t % 256) >= 128) != (a >= 128));
      cy = t >= 160;
      r = cy ? (t + 96) % 256 : t;
      if (cm) begin n = r >= 128; z = r == 0; end
      else    begin n = (t % 256) >= 128; z = bz; end
    end else if (dm) begin
      lo = (a % 16) - (b % 16) - (1 - c);
      bw = lo < 0;
      lo4 = (bw && !cm) ? (lo - 6 + 32) % 16 : (lo + 32) % 16;
      t = (a / 16) * 16 + lo4 - (b / 16) * 16 - bw * 16;
      if (t < 0) t = t - 96;
      r = (t + 512) % 256;
      if (cm && bw) r = (r + 250) % 256;
      if (cm) begin n = r >= 128; z = r == 0; end
    end
    return (r << 4) | (n << 3) | (v << 2) | (z << 1) | cy;
  endfunction

  function automatic string tag_res(input int sb, input int dm, input int cm);
    if (!dm) return sb ? "R4" : "R3";
    if (!sb) return "R5";
    return cm ? "R10" : "R8";
  endfunction

  function automatic string tag_flg(input int sb, input int dm, input int cm);
    if (!dm) return sb ? "R4" : "R3";
    if (!sb) return cm ? "R7" : "R6";
    return cm ? "R11" : "R9";
  endfunction

  // call right after a falling edge; returns right after the next one
  task automatic run_op(input int a, input int b, input int c, input int sb,
                        input int dm, input int cm);
    int e;
    op_a_i = 8'(a); op_b_i = 8'(b); carry_i = c[0];
    sub_i = sb[0]; dec_i = dm[0]; cmos_i = cm[0]; valid_i = 1'b1;
    e = model(a, b, c, sb, dm, cm);
    @(negedge clk);
    check(tag_res(sb, dm, cm), int'(result_o), e >> 4);
    check(tag_flg(sb, dm, cm), int'({flag_n_o, flag_v_o, flag_z_o, flag_c_o}), e & 15);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int hold_res, hold_flg;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is low
    check("R1", int'({valid_o, result_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", int'(valid_o), 0);

    // directed corners
    run_op(8'h99, 8'h01, 0, 0, 1, 0);
    run_op(8'h99, 8'h99, 1, 0, 1, 1);
    run_op(8'h00, 8'h01, 1, 1, 1, 0);
    run_op(8'h00, 8'h01, 1, 1, 1, 1);
    run_op(8'hFF, 8'hFF, 1, 0, 1, 0);
    run_op(8'h7F, 8'h01, 0, 0, 0, 0);
    run_op(8'h80, 8'h01, 1, 1, 0, 0);
    check("R2", int'(valid_o), 1);

    // R2: strobe low leaves result and flags untouched
    hold_res = int'(result_o);
    hold_flg = int'({flag_n_o, flag_v_o, flag_z_o, flag_c_o});
    valid_i = 1'b0; op_a_i = 8'h12; op_b_i = 8'h34; dec_i = 1'b1; sub_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", int'(valid_o), 0);
    check("R2", int'(result_o), hold_res);
    check("R2", int'({flag_n_o, flag_v_o, flag_z_o, flag_c_o}), hold_flg);

    // sweeps: all a, strided b, every mode
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 11) begin
          run_op(a, b, cfg & 1, (cfg >> 1) & 1, (cfg >> 2) & 1, (cfg >> 3) & 1);
        end
      end
    end
    valid_i = 1'b0;
    @(negedge clk);
    check("R2", int'(valid_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule